// File: doc/BRIEF.md
# SPI Serial Clock Generator with Two Divider Schemes

This block derives the serial clock of an SPI master from the module clock. A 13-bit rate word picks one of two divider families. One family divides by a power of two taken from a 4-bit exponent field. The other divides by an even integer taken from an 8-bit field. Clock polarity and phase come in as configuration levels. Besides the clock waveform, the block emits two single-cycle strobes for a neighbouring shift engine. The launch strobe marks the edge on which the next bit is driven, and the sample strobe marks the edge on which the incoming bit is captured.

The clock runs only while both the enable and the transfer-active input are high. A small state machine walks through three states:

- `ST_IDLE`: the clock is parked at the polarity level.
- `ST_REST`: the clock is at the idle level while running.
- `ST_DRIVE`: the clock is at the opposite level.

The named transitions are:

- **start** (`ST_IDLE`→`ST_REST`): the divisor is latched at this point.
- **lead** (`ST_REST`→`ST_DRIVE`): the leading edge.
- **trail** (`ST_DRIVE`→`ST_REST`): the trailing edge, taken when the run request is still high.
- **finish** (`ST_DRIVE`→`ST_IDLE`): the trailing edge with the run request low.
- **abandon** (`ST_REST`→`ST_IDLE`): taken with the run request low, so no edge is issued.

The run request is sampled only at half-period boundaries.

Top module: `spiclk_gen`

## Requirements
- R1: With rate bit 12 at 0, bits 11:8 hold an exponent n. The serial clock period is then 2^(n+1) module cycles, with each half lasting 2^n cycles, and bits 7:0 have no effect.
- R2: With rate bit 12 at 1, bits 7:0 hold a value m. The period is then 2*(m+1) module cycles, with each half lasting m+1 cycles, and bits 11:8 have no effect.
- R3: The smallest division is 2: n=0 or m=0 makes the serial clock change level on every module cycle.
- R4: While no transfer runs, including right after reset, the serial clock equals the polarity input.
- R5: The divisor is captured when a transfer starts. Rate changes during a transfer do not alter its half-period.
- R6: Every serial clock edge comes with exactly one strobe in the same cycle, and no strobe appears without an edge. The leading edge moves away from the polarity level. With phase 0, sample goes with the leading edge and launch with the trailing edge; with phase 1, the roles swap.
- R7: Each strobe is high for one module cycle at a time.
- R8: The clock starts only when enable and transfer-active are both high. The first edge appears at the (H+1)-th rising module-clock edge after both go high, where H is the half-period.
- R9: Once a leading edge has been issued, its trailing edge always follows, after which the clock rests at the polarity level. If the run request is low at the end of an idle-level half, no further leading edge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_cfg_i | input | 13 | Scheme select (bit 12), exponent (11:8), linear divisor (7:0) |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase: 0 samples on the leading edge, 1 launches on it |
| enable_i | input | 1 | Block enable |
| xfer_active_i | input | 1 | Transfer request; gates the clock |
| sck_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe: drive the next bit |
| sample_o | output | 1 | One-cycle strobe: capture the incoming bit |

## Verification
A wrong half-period count or a wrongly latched divisor shows up at the second serial clock edge of a transfer, as a gap between edges that differs from the expected one. A wrong state transition shows up within one half-period, either as a missing trailing edge or as a clock left at the wrong level. A swapped or misaligned strobe is visible at the very first edge, because every edge is compared against the strobe outputs in the same cycle. Sweeping both schemes across small fields, the largest linear field and all four polarity and phase combinations exposes each of these faults within a few edges.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

    // Serial clock generator states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // parked at polarity level, not running
        ST_REST  = 2'd1,   // running, clock at polarity level
        ST_DRIVE = 2'd2    // running, clock at opposite level
    } sck_state_e;

    // Width needed to hold the largest half-period of either scheme
    function automatic int half_width(input int pow_w, input int lin_w);
        int pow_half_w;
        pow_half_w = 1 << pow_w;
        return (pow_half_w > lin_w + 1) ? pow_half_w : lin_w + 1;
    endfunction

endpackage

// File: rtl/spiclk_div_sel.sv
module spiclk_div_sel #(
    parameter int POW_FIELD_W = 4,
    parameter int LIN_FIELD_W = 8,
    parameter int HALF_W      = 16,
    localparam int CFG_W      = 1 + POW_FIELD_W + LIN_FIELD_W
) (
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [HALF_W-1:0] half_o
);

    localparam int SEL_BIT = CFG_W - 1;

    logic                   scheme_lin;
    logic [POW_FIELD_W-1:0] pow_field;
    logic [LIN_FIELD_W-1:0] lin_field;

    assign scheme_lin = cfg_i[SEL_BIT];
    assign pow_field  = cfg_i[LIN_FIELD_W +: POW_FIELD_W];
    assign lin_field  = cfg_i[LIN_FIELD_W-1:0];

    // Half-period in module cycles for the selected scheme
    always_comb begin
        if (scheme_lin) begin
            half_o = HALF_W'(lin_field) + HALF_W'(1);
        end else begin
            half_o = HALF_W'(1) << pow_field;
        end
    end

    initial begin
        AST_HALF_WIDTH_FITS: assert (HALF_W >= LIN_FIELD_W + 1 && HALF_W >= (1 << POW_FIELD_W)); // R1
    end

endmodule

// File: rtl/spiclk_strobe.sv
module spiclk_strobe (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lead_evt_i,
    input  logic trail_evt_i,
    input  logic cpha_i,
    output logic launch_o,
    output logic sample_o
);

    logic launch_q;
    logic sample_q;

    // Registered so that each strobe lines up with the clock level change
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            launch_q <= 1'b0;
            sample_q <= 1'b0;
        end else begin
            launch_q <= cpha_i ? lead_evt_i  : trail_evt_i;
            sample_q <= cpha_i ? trail_evt_i : lead_evt_i;
        end
    end

    assign launch_o = launch_q;
    assign sample_o = sample_q;

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(launch_o && sample_o)); // R6
    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_o |=> !launch_o); // R7
    AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> !sample_o); // R7

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
    import spiclk_pkg::*;
#(
    parameter int POW_FIELD_W = 4,
    parameter int LIN_FIELD_W = 8,
    localparam int CFG_W      = 1 + POW_FIELD_W + LIN_FIELD_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] rate_cfg_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic             enable_i,
    input  logic             xfer_active_i,
    output logic             sck_o,
    output logic             launch_o,
    output logic             sample_o
);

    localparam int HALF_W = half_width(POW_FIELD_W, LIN_FIELD_W);

    sck_state_e        state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] half_q, half_d;
    logic [HALF_W-1:0] half_sel;
    logic              run;
    logic              cnt_done;
    logic              lead_evt;
    logic              trail_evt;

    assign run      = enable_i & xfer_active_i;
    assign cnt_done = (cnt_q == '0);

    spiclk_div_sel #(
        .POW_FIELD_W (POW_FIELD_W),
        .LIN_FIELD_W (LIN_FIELD_W),
        .HALF_W      (HALF_W)
    ) div_sel_i (
        .cfg_i  (rate_cfg_i),
        .half_o (half_sel)
    );

    // Next-state and counter logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        half_d    = half_q;
        lead_evt  = 1'b0;
        trail_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin                       // start
                    state_d = ST_REST;
                    half_d  = half_sel;
                    cnt_d   = half_sel - HALF_W'(1);
                end
            end
            ST_REST: begin
                if (!cnt_done) begin
                    cnt_d = cnt_q - HALF_W'(1);
                end else if (run) begin              // lead
                    state_d  = ST_DRIVE;
                    cnt_d    = half_q - HALF_W'(1);
                    lead_evt = 1'b1;
                end else begin                       // abandon
                    state_d = ST_IDLE;
                end
            end
            ST_DRIVE: begin
                if (!cnt_done) begin
                    cnt_d = cnt_q - HALF_W'(1);
                end else begin                       // trail or finish
                    trail_evt = 1'b1;
                    cnt_d     = half_q - HALF_W'(1);
                    state_d   = run ? ST_REST : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            half_q  <= HALF_W'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
        end
    end

    // Outputs
    always_comb begin
        sck_o = cpol_i ^ (state_q == ST_DRIVE);
    end

    spiclk_strobe strobe_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lead_evt_i  (lead_evt),
        .trail_evt_i (trail_evt),
        .cpha_i      (cpha_i),
        .launch_o    (launch_o),
        .sample_o    (sample_o)
    );

    AST_HALF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(half_q)); // R5
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |-> (cnt_q < half_q)); // R1
    AST_NO_START_WITHOUT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !(enable_i && xfer_active_i)) |=> (state_q == ST_IDLE)); // R8
    AST_EDGE_HAS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($stable(cpol_i) && !$stable(sck_o)) |-> (launch_o || sample_o)); // R6

endmodule

// File: tb/spiclk_gen_tb_top.sv
`timescale 1ns/100ps
module spiclk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] rate_cfg;
    logic        cpol, cpha, enable, xfer_active;
    logic        sck, launch, sample;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    // Monitor state
    bit    mon_on = 1'b0;
    bit    first_seen;
    int    gap;
    int    lead_cnt;
    int    trail_cnt;
    int    exp_half;
    string cur_tag;
    logic  prev_sck = 1'b0;

    always #2.5 clk = ~clk;

    spiclk_gen dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .rate_cfg_i    (rate_cfg),
        .cpol_i        (cpol),
        .cpha_i        (cpha),
        .enable_i      (enable),
        .xfer_active_i (xfer_active),
        .sck_o         (sck),
        .launch_o      (launch),
        .sample_o      (sample)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Edge monitor: spacing and strobe alignment
    always @(negedge clk) begin
        if (mon_on) begin
            if (sck !== prev_sck) begin
                bit leading;
                bit exp_s;
                leading = (sck !== cpol);
                exp_s   = leading ^ cpha;
                if (first_seen) chk(gap == exp_half - 1, {cur_tag, " half-period"}, gap + 1, exp_half);
                chk(sample == exp_s,  "R6 sample strobe at edge", int'(sample), int'(exp_s));
                chk(launch == !exp_s, "R6 launch strobe at edge", int'(launch), int'(!exp_s));
                if (leading) lead_cnt++; else trail_cnt++;
                first_seen = 1'b1;
                gap = 0;
            end else begin
                gap++;
                chk(!launch && !sample, "R7 strobe without edge", int'(launch | sample), 0);
            end
        end
        prev_sck = sck;
    end

    task automatic run_xfer(input bit sel, input int fld, input bit pol, input bit pha,
                            input int k, input bit scramble);
        int n;
        mon_on = 1'b0;
        @(negedge clk);
        if (sel) begin
            rate_cfg = {1'b1, 4'h9, 8'(fld)};        // R2: exponent field ignored
            exp_half = fld + 1;
        end else begin
            rate_cfg = {1'b0, 4'(fld), 8'hA5};        // R1: linear field ignored
            exp_half = 1 << fld;
        end
        cpol = pol;
        cpha = pha;
        enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(sck == pol, "R4 idle level before transfer", int'(sck), int'(pol));
        first_seen = 1'b0;
        gap = 0;
        lead_cnt = 0;
        trail_cnt = 0;
        cur_tag = scramble ? "R5" : (sel ? "R2" : "R1");
        mon_on = 1'b1;
        xfer_active = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sck == pol && n < 2000);
        chk(n == exp_half + 1, "R8 first edge delay", n, exp_half + 1);
        if (scramble) rate_cfg = ~rate_cfg;           // R5: must not affect this transfer
        n = 0;
        while (lead_cnt < k && n < 5000) begin
            @(posedge clk);
            n++;
        end
        @(negedge clk);
        xfer_active = 1'b0;
        repeat (2 * exp_half + 6) @(negedge clk);
        chk(lead_cnt == k,  "R9 leading edge count", lead_cnt, k);
        chk(trail_cnt == k, "R9 trailing edge count", trail_cnt, k);
        chk(sck == pol, "R9 clock rests at polarity", int'(sck), int'(pol));
        mon_on = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        rate_cfg = '0;
        cpol = 1'b0;
        cpha = 1'b0;
        enable = 1'b0;
        xfer_active = 1'b0;
        repeat (3) @(negedge clk);
        chk(sck == 1'b0, "R4 reset level", int'(sck), 0);
        chk(!launch && !sample, "R7 reset strobes", int'(launch | sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep both schemes, all polarity/phase modes
        for (int mode = 0; mode < 4; mode++) begin
            for (int n = 0; n <= 5; n++) run_xfer(1'b0, n, mode[1], mode[0], 3, 1'b0);   // R1, R3 at n=0
            for (int m = 0; m <= 7; m++) run_xfer(1'b1, m, mode[1], mode[0], 3, 1'b0);   // R2, R3 at m=0
            run_xfer(1'b1, 255, mode[1], mode[0], 2, 1'b0);
        end

        // R3: minimum division toggles every cycle
        run_xfer(1'b0, 0, 1'b0, 1'b0, 5, 1'b0);
        run_xfer(1'b1, 0, 1'b1, 1'b1, 5, 1'b0);

        // R5: rate change mid-transfer ignored
        run_xfer(1'b1, 3, 1'b0, 1'b1, 4, 1'b1);
        run_xfer(1'b0, 2, 1'b1, 1'b0, 4, 1'b1);

        // R8: enable low gates the clock
        mon_on = 1'b0;
        @(negedge clk);
        rate_cfg = {1'b1, 4'h0, 8'd1};
        cpol = 1'b0;
        cpha = 1'b0;
        exp_half = 2;
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        lead_cnt = 0;
        trail_cnt = 0;
        first_seen = 1'b0;
        mon_on = 1'b1;
        xfer_active = 1'b1;
        repeat (40) @(negedge clk);
        chk(lead_cnt + trail_cnt == 0, "R8 no edges while disabled", lead_cnt + trail_cnt, 0);
        chk(sck == 1'b0, "R8 level while disabled", int'(sck), 0);
        xfer_active = 1'b0;
        enable = 1'b1;

        // R9: request dropped before the first leading edge
        @(negedge clk);
        rate_cfg = {1'b1, 4'h0, 8'd3};                // half-period 4
        exp_half = 4;
        cpol = 1'b1;
        mon_on = 1'b0;
        @(negedge clk);
        @(negedge clk);
        lead_cnt = 0;
        trail_cnt = 0;
        first_seen = 1'b0;
        mon_on = 1'b1;
        xfer_active = 1'b1;
        repeat (2) @(negedge clk);
        xfer_active = 1'b0;
        repeat (20) @(negedge clk);
        chk(lead_cnt + trail_cnt == 0, "R9 abandoned before leading edge", lead_cnt + trail_cnt, 0);
        chk(sck == 1'b1, "R9 level after abandon", int'(sck), 1);
        mon_on = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule